// File: doc/BRIEF.md
# I2C Master Register and FIFO Front End

This block is the software-facing half of an I2C master. A 32-bit register interface takes transfer command words and queues them in a command FIFO. Each word asks for an optional START before its byte and an optional STOP after it, and carries either a data byte or an address byte whose bit 0 gives the direction. To read, software pushes one command per byte it wants returned. A separate bus bit engine, not part of this block, drives SCL and SDA. It takes one queued command at a time from a small handoff state machine and returns each received byte, which lands in a receive FIFO that software drains through a read-popping data register.

The block also holds the control, interrupt enable, interrupt status and busy status registers, the two FIFO level registers, and three timing counts that go to the bit engine unchanged. Transmit-ready and receive-ready flags follow programmable FIFO fill thresholds. Receive overflow, arbitration loss and NACK are sticky flags cleared by writing 1. One interrupt line is the OR of the status bits masked by the enables. Clearing the enable bit holds both FIFOs empty, so toggling it resets the controller.

The handoff state machine has two states. In HS_IDLE nothing is offered to the engine. Transition T_LOAD goes to HS_OFFER when the core is enabled and the command FIFO holds an entry. In HS_OFFER the head entry is presented on the command outputs. Transition T_TAKE goes back to HS_IDLE when the engine accepts the entry, and the entry is popped. Transition T_ABORT goes back to HS_IDLE when the core is disabled.

Top module: `i2c_regfront`

## Requirements
- R1: After reset, control, interrupt enable, the timing counts and the sticky flags read 0, both FIFO levels read 0, the status register reads 0, cmd_valid and irq are low, and interrupt status reads 0x01 because transmit-ready is set with an empty command FIFO and threshold 0.
- R2: Register map (byte offsets). 0x08 is control, bits 5:0 read back. 0x0C is interrupt enable, bits 4:0 read back. 0x20, 0x24 and 0x28 are the SCL low, SCL high and SDA hold counts, CNT_W bits each, read back and driven on scl_low_cnt, scl_high_cnt and sda_hold_cnt. Offset 0x00 and unmapped offsets read 0.
- R3: A write to 0x00 while enabled pushes {bit 9 START, bit 8 STOP, bits 7:0 byte} into the command FIFO, and 0x18 reads its occupancy. A write when the FIFO already holds FIFO_DEPTH entries is dropped.
- R4: Commands go to the engine oldest first, one at a time. cmd_valid stays high with cmd_start, cmd_stop and cmd_byte stable until cmd_accept is seen in the same cycle, which pops that entry.
- R5: A cycle with rx_valid high while enabled pushes rx_byte. A read of 0x04 returns the oldest byte in bits 7:0 and pops it; on an empty FIFO it returns 0 and changes nothing. 0x1C reads the occupancy.
- R6: A received byte that arrives while the receive FIFO is full is dropped and sets interrupt status bit 4 (receive overflow).
- R7: Interrupt status bit 0 (transmit ready) is 1 while the command level is at or below control bits 3:2. Bit 1 (receive ready) is 1 while the receive level is above control bits 5:4.
- R8: An arb_lost pulse sets status bit 3 and a nack_seen pulse sets status bit 2; both are sticky. Writing 1 to bits 4:2 of 0x10 clears them, and writing 1 to bits 1:0 has no effect.
- R9: irq is high exactly when some interrupt status bit and the matching enable bit at 0x0C are both 1.
- R10: While control bit 0 is 0, both FIFOs are held empty, command writes and received bytes are discarded without setting overflow, and cmd_valid is low. After re-enabling, both FIFOs start empty.
- R11: Status register 0x14 bit 0 reads 1 while eng_busy is high or a command is being offered, and 0 otherwise.
- R12: core_en follows control bit 0 and fast_mode follows control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at 0x04) |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request |
| core_en | output | 1 | Core enable to the bit engine |
| fast_mode | output | 1 | Fast bus speed select |
| scl_low_cnt | output | CNT_W | SCL low count |
| scl_high_cnt | output | CNT_W | SCL high count |
| sda_hold_cnt | output | CNT_W | SDA hold count |
| cmd_valid | output | 1 | A command is offered to the engine |
| cmd_start | output | 1 | Offered command requests START |
| cmd_stop | output | 1 | Offered command requests STOP |
| cmd_byte | output | 8 | Offered data or address byte |
| cmd_accept | input | 1 | Engine takes the offered command |
| eng_busy | input | 1 | Engine is active on the bus |
| rx_valid | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| arb_lost | input | 1 | Arbitration lost pulse |
| nack_seen | input | 1 | NACK detected pulse |

## Verification
The bench builds the block with FIFO_DEPTH = 4 and CNT_W = 16. A depth of four means a handful of writes or received bytes reaches the full boundary, so the dropped fifth command and the overflowing fifth byte are both exercised. The 2-bit threshold fields then cover every level the FIFO can report, so the ready flags can be watched as they cross. A 16-bit count also lets a 20-bit write show truncation on read-back.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;

    localparam int unsigned ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFF_CMD  = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_RXD  = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_IER  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_ISR  = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_STAT = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_CLVL = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_RLVL = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_SCLL = 6'h20;
    localparam logic [ADDR_W-1:0] OFF_SCLH = 6'h24;
    localparam logic [ADDR_W-1:0] OFF_HOLD = 6'h28;

    localparam int unsigned CMD_W   = 10;
    localparam int unsigned BIT_STA = 9;
    localparam int unsigned BIT_STO = 8;

    localparam int unsigned ISR_W = 5;

    typedef enum logic [0:0] {
        HS_IDLE  = 1'b0,
        HS_OFFER = 1'b1
    } hs_state_e;

endpackage

// File: rtl/i2cf_fifo.sv
module i2cf_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [LW-1:0]    level,
    output logic             full,
    output logic             empty
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp_q, rp_q;
    logic [LW-1:0]    cnt_q;
    logic             do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == LW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign level   = cnt_q;
    assign rdata   = mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wp_q] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= bump(wp_q);
            if (do_pop)  rp_q <= bump(rp_q);
            cnt_q <= cnt_q + LW'(do_push) - LW'(do_pop);
        end
    end

    // R3
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LW'(DEPTH));

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);

endmodule

// File: rtl/i2cf_handoff.sv
module i2cf_handoff
    import i2cf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fifo_empty,
    input  logic cmd_accept,
    output logic offer,
    output logic pop
);
    hs_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= HS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HS_IDLE:  if (en && !fifo_empty)  st_d = HS_OFFER;
            HS_OFFER: if (!en || cmd_accept)  st_d = HS_IDLE;
        endcase
    end

    always_comb begin
        offer = (st_q == HS_OFFER) && en;
        pop   = offer && cmd_accept;
    end

    // R4
    offer_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        offer |-> !fifo_empty);

    // R4
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (offer && !cmd_accept) |=> (offer || !en));

endmodule

// File: rtl/i2cf_irq.sv
module i2cf_irq
    import i2cf_pkg::*;
#(
    parameter int unsigned LW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_rxof,
    input  logic             set_arb,
    input  logic             set_nack,
    input  logic             clr_wr,
    input  logic [ISR_W-1:0] clr_mask,
    input  logic [ISR_W-1:0] ier,
    input  logic [LW-1:0]    cmd_level,
    input  logic [LW-1:0]    rx_level,
    input  logic [1:0]       cmd_thr,
    input  logic [1:0]       rx_thr,
    output logic [ISR_W-1:0] isr,
    output logic             irq
);
    logic [2:0] sticky_q, sticky_set, sticky_clr;
    logic       txrdy, rxrdy;

    assign sticky_set = {set_rxof, set_arb, set_nack};
    assign sticky_clr = clr_wr ? clr_mask[4:2] : 3'b000;

    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= (sticky_q & ~sticky_clr) | sticky_set;
    end

    always_comb begin
        txrdy = (cmd_level <= LW'(cmd_thr));
        rxrdy = (rx_level > LW'(rx_thr));
        isr   = {sticky_q, rxrdy, txrdy};
        irq   = |(isr & ier);
    end

    // R8
    nack_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_mask[2] && !set_nack) |=> !isr[2]);

    // R8
    arb_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (isr[3] && !(clr_wr && clr_mask[3])) |=> isr[3]);

endmodule

// File: rtl/i2c_regfront.sv
module i2c_regfront
    import i2cf_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 4,
    parameter int unsigned CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              core_en,
    output logic              fast_mode,
    output logic [CNT_W-1:0]  scl_low_cnt,
    output logic [CNT_W-1:0]  scl_high_cnt,
    output logic [CNT_W-1:0]  sda_hold_cnt,
    output logic              cmd_valid,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic [7:0]        cmd_byte,
    input  logic              cmd_accept,
    input  logic              eng_busy,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              arb_lost,
    input  logic              nack_seen
);
    localparam int unsigned LW = $clog2(FIFO_DEPTH + 1);

    logic [5:0]       ctrl_q;
    logic [ISR_W-1:0] ier_q;
    logic [CNT_W-1:0] low_q, high_q, hold_q;

    logic             flush;
    logic             cmd_push, cmd_pop, cmd_full, cmd_empty;
    logic [CMD_W-1:0] cmd_head;
    logic [LW-1:0]    cmd_level;
    logic             rx_push, rx_pop, rx_full, rx_empty;
    logic [7:0]       rx_head;
    logic [LW-1:0]    rx_level;
    logic [ISR_W-1:0] isr;
    logic             busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ier_q  <= '0;
            low_q  <= '0;
            high_q <= '0;
            hold_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFF_CTRL: ctrl_q <= reg_wdata[5:0];
                OFF_IER:  ier_q  <= reg_wdata[ISR_W-1:0];
                OFF_SCLL: low_q  <= reg_wdata[CNT_W-1:0];
                OFF_SCLH: high_q <= reg_wdata[CNT_W-1:0];
                OFF_HOLD: hold_q <= reg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    assign core_en      = ctrl_q[0];
    assign fast_mode    = ctrl_q[1];
    assign scl_low_cnt  = low_q;
    assign scl_high_cnt = high_q;
    assign sda_hold_cnt = hold_q;
    assign flush        = !core_en;

    assign cmd_push = reg_wr && (reg_addr == OFF_CMD) && core_en;
    assign rx_push  = rx_valid && core_en;
    assign rx_pop   = reg_rd && (reg_addr == OFF_RXD);

    i2cf_fifo #(.WIDTH(CMD_W), .DEPTH(FIFO_DEPTH), .LW(LW)) u_cmd_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (cmd_push),
        .wdata (reg_wdata[CMD_W-1:0]),
        .pop   (cmd_pop),
        .rdata (cmd_head),
        .level (cmd_level),
        .full  (cmd_full),
        .empty (cmd_empty)
    );

    i2cf_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH), .LW(LW)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (rx_push),
        .wdata (rx_byte),
        .pop   (rx_pop),
        .rdata (rx_head),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    i2cf_handoff u_handoff (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (core_en),
        .fifo_empty (cmd_empty),
        .cmd_accept (cmd_accept),
        .offer      (cmd_valid),
        .pop        (cmd_pop)
    );

    assign cmd_start = cmd_valid && cmd_head[BIT_STA];
    assign cmd_stop  = cmd_valid && cmd_head[BIT_STO];
    assign cmd_byte  = cmd_valid ? cmd_head[7:0] : 8'h00;

    i2cf_irq #(.LW(LW)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_rxof  (rx_push && rx_full),
        .set_arb   (arb_lost),
        .set_nack  (nack_seen),
        .clr_wr    (reg_wr && (reg_addr == OFF_ISR)),
        .clr_mask  (reg_wdata[ISR_W-1:0]),
        .ier       (ier_q),
        .cmd_level (cmd_level),
        .rx_level  (rx_level),
        .cmd_thr   (ctrl_q[3:2]),
        .rx_thr    (ctrl_q[5:4]),
        .isr       (isr),
        .irq       (irq)
    );

    assign busy = eng_busy || cmd_valid;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_RXD:  reg_rdata = rx_empty ? 32'h0 : {24'h0, rx_head};
            OFF_CTRL: reg_rdata = {26'h0, ctrl_q};
            OFF_IER:  reg_rdata = 32'(ier_q);
            OFF_ISR:  reg_rdata = 32'(isr);
            OFF_STAT: reg_rdata = {31'h0, busy};
            OFF_CLVL: reg_rdata = 32'(cmd_level);
            OFF_RLVL: reg_rdata = 32'(rx_level);
            OFF_SCLL: reg_rdata = 32'(low_q);
            OFF_SCLH: reg_rdata = 32'(high_q);
            OFF_HOLD: reg_rdata = 32'(hold_q);
            default:  reg_rdata = '0;
        endcase
    end

    // R6
    rx_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en && rx_valid && rx_full) |=> isr[4]);

    // R10
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en |=> (cmd_level == '0 && rx_level == '0));

    // R4
    cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_accept) |=>
            (!core_en || (cmd_valid && $stable({cmd_start, cmd_stop, cmd_byte}))));

endmodule

// File: tb/i2c_regfront_tb.sv
`timescale 1ns/1ps
module i2c_regfront_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, core_en, fast_mode;
    logic [15:0] scl_low_cnt, scl_high_cnt, sda_hold_cnt;
    logic        cmd_valid, cmd_start, cmd_stop;
    logic [7:0]  cmd_byte;
    logic        cmd_accept = 1'b0, eng_busy = 1'b0, rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        arb_lost = 1'b0, nack_seen = 1'b0;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    i2c_regfront #(.FIFO_DEPTH(4), .CNT_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .core_en(core_en), .fast_mode(fast_mode),
        .scl_low_cnt(scl_low_cnt), .scl_high_cnt(scl_high_cnt),
        .sda_hold_cnt(sda_hold_cnt), .cmd_valid(cmd_valid),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_byte(cmd_byte),
        .cmd_accept(cmd_accept), .eng_busy(eng_busy), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .arb_lost(arb_lost), .nack_seen(nack_seen)
    );

    // {read, addr[5:0], data_or_expected[31:0]}
    localparam int NV = 14;
    localparam logic [38:0] VEC [NV] = '{
        {1'b0, 6'h08, 32'h0000001B},
        {1'b1, 6'h08, 32'h0000001B},
        {1'b0, 6'h0C, 32'h000000FF},
        {1'b1, 6'h0C, 32'h0000001F},
        {1'b0, 6'h20, 32'h00012345},
        {1'b1, 6'h20, 32'h00002345},
        {1'b0, 6'h24, 32'h0000ABCD},
        {1'b1, 6'h24, 32'h0000ABCD},
        {1'b0, 6'h28, 32'h00000007},
        {1'b1, 6'h28, 32'h00000007},
        {1'b1, 6'h14, 32'h00000000},
        {1'b1, 6'h10, 32'h00000001},
        {1'b1, 6'h18, 32'h00000000},
        {1'b1, 6'h00, 32'h00000000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic rx_in(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic take();
        @(negedge clk);
        cmd_accept = 1'b1;
        @(negedge clk);
        cmd_accept = 1'b0;
        @(negedge clk);
    endtask

    task automatic offer_chk(input string req, input logic [9:0] w);
        #1;
        check(req, {22'h0, cmd_valid, cmd_start, cmd_stop, cmd_byte},
              {22'h0, 1'b1, w[9], w[8], w[7:0]});
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 ctrl", 6'h08, 32'h0);
        rd_chk("R1 ier", 6'h0C, 32'h0);
        rd_chk("R1 isr", 6'h10, 32'h1);
        rd_chk("R1 status", 6'h14, 32'h0);
        rd_chk("R1 cmd level", 6'h18, 32'h0);
        rd_chk("R1 rx level", 6'h1C, 32'h0);
        check("R1 irq/cmd_valid", {30'h0, irq, cmd_valid}, 32'h0);

        // R2 register map table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][38]) rd_chk("R2 table", VEC[i][37:32], VEC[i][31:0]);
            else            wr(VEC[i][37:32], VEC[i][31:0]);
        end
        check("R2 timing outputs", {scl_low_cnt, sda_hold_cnt}, 32'h2345_0007);
        check("R2 scl high out", {16'h0, scl_high_cnt}, 32'h0000ABCD);
        check("R12 en/fast", {30'h0, core_en, fast_mode}, 32'h3);
        check("R9 irq on txrdy", {31'h0, irq}, 32'h1);
        wr(6'h0C, 32'h0);

        // R3 command queue, fifth write dropped
        wr(6'h00, 32'h2A0);
        wr(6'h00, 32'h011);
        wr(6'h00, 32'h022);
        wr(6'h00, 32'h133);
        wr(6'h00, 32'h044);
        rd_chk("R3 cmd level full", 6'h18, 32'h4);
        rd_chk("R7 txrdy low above thr", 6'h10, 32'h0);
        rd_chk("R11 busy while offering", 6'h14, 32'h1);

        // R4 ordered handoff
        offer_chk("R4 first", 10'h2A0);
        repeat (3) @(negedge clk);
        offer_chk("R4 held", 10'h2A0);
        take();
        offer_chk("R4 second", 10'h011);
        take();
        offer_chk("R4 third", 10'h022);
        take();
        offer_chk("R4 fourth", 10'h133);
        take();
        #1 check("R3 dropped fifth not offered", {31'h0, cmd_valid}, 32'h0);
        rd_chk("R3 cmd level empty", 6'h18, 32'h0);
        rd_chk("R11 idle", 6'h14, 32'h0);

        // R5 R6 R7 receive path, rx threshold 1
        rx_in(8'h5A);
        rd_chk("R7 rxrdy at thr", 6'h10, 32'h01);
        rx_in(8'h6B);
        rd_chk("R7 rxrdy above thr", 6'h10, 32'h03);
        rx_in(8'h7C);
        rx_in(8'h8D);
        rd_chk("R5 rx level", 6'h1C, 32'h4);
        rx_in(8'hEE);
        rd_chk("R6 overflow flag", 6'h10, 32'h13);
        rd_chk("R6 level unchanged", 6'h1C, 32'h4);
        rd_chk("R5 pop 1", 6'h04, 32'h5A);
        rd_chk("R5 pop 2", 6'h04, 32'h6B);
        rd_chk("R5 pop 3", 6'h04, 32'h7C);
        rd_chk("R6 pop 4 not overwritten", 6'h04, 32'h8D);
        rd_chk("R5 empty read", 6'h04, 32'h0);
        rd_chk("R5 level zero", 6'h1C, 32'h0);

        // R8 sticky flags and write-1-to-clear
        wr(6'h10, 32'h03);
        rd_chk("R8 live bits unaffected", 6'h10, 32'h11);
        @(negedge clk); nack_seen = 1'b1; @(negedge clk); nack_seen = 1'b0;
        rd_chk("R8 nack sticky", 6'h10, 32'h15);
        @(negedge clk); arb_lost = 1'b1; @(negedge clk); arb_lost = 1'b0;
        rd_chk("R8 arb sticky", 6'h10, 32'h1D);

        // R9 masking
        #1 check("R9 irq masked", {31'h0, irq}, 32'h0);
        wr(6'h0C, 32'h04);
        #1 check("R9 irq nack enabled", {31'h0, irq}, 32'h1);
        wr(6'h10, 32'h04);
        #1 check("R9 irq after clear", {31'h0, irq}, 32'h0);
        rd_chk("R8 nack cleared", 6'h10, 32'h19);
        wr(6'h10, 32'h18);
        rd_chk("R8 all sticky cleared", 6'h10, 32'h01);
        wr(6'h0C, 32'h0);

        // R10 disable flushes and discards
        wr(6'h00, 32'h055);
        wr(6'h00, 32'h066);
        rx_in(8'h77);
        wr(6'h08, 32'h1A);
        rd_chk("R10 cmd flushed", 6'h18, 32'h0);
        rd_chk("R10 rx flushed", 6'h1C, 32'h0);
        #1 check("R10 no offer", {30'h0, cmd_valid, core_en}, 32'h0);
        wr(6'h00, 32'h099);
        rx_in(8'h88);
        wr(6'h08, 32'h1B);
        rd_chk("R10 cmd empty after enable", 6'h18, 32'h0);
        rd_chk("R10 rx empty after enable", 6'h1C, 32'h0);
        rd_chk("R10 no overflow while off", 6'h10, 32'h01);
        #1 check("R10 nothing offered", {31'h0, cmd_valid}, 32'h0);

        // R11 engine busy
        @(negedge clk); eng_busy = 1'b1;
        rd_chk("R11 engine busy", 6'h14, 32'h1);
        @(negedge clk); eng_busy = 1'b0;
        rd_chk("R11 engine idle", 6'h14, 32'h0);

        // R12 speed select
        wr(6'h08, 32'h19);
        #1 check("R12 standard speed", {30'h0, core_en, fast_mode}, 32'h2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule